// File: doc/BRIEF.md
# Single/Double Edge PWM Output Generator

This block produces one pulse-width-modulated level from a counter it does not own. A shared counter runs from 0 up to a period value, then returns to 0 and pulses a one-cycle cycle-start strobe. The block compares the counter against a set point and a clear point and drives the output high or low from those comparisons. In single-edge mode the output rises at every cycle start and falls at the clear point. In double-edge mode the set point raises the output and the clear point lowers it.

The period, set point, clear point and mode arrive as pending values. The block copies them into active registers only on a cycle-start edge while the counter is enabled, so a new pulse shape always begins on a clean cycle boundary. A value of 0 and a value equal to the period both mean "at the boundary". A value above the period never fires. When both a set and a clear fire together, the clear wins. In double-edge mode, a boundary-equal value from the previous cycle can fire one more time on the boundary where new values take over.

Top module: `pwm_edge_gen`

## Requirements
- R1: In single-edge mode (mode_nxt = 0 at the boundary), the output is high after each cycle-start edge, unless the clear point is 0 or equal to the period.
- R2: In single-edge mode, the output goes low on the edge where the counter equals a clear point between 1 and period-1. A clear point above the period leaves the output high for the whole cycle.
- R3: In single-edge mode, a clear point of 0, or one equal to the period, keeps the output low continuously.
- R4: In double-edge mode (mode_nxt = 1 at the boundary), the output goes high on the edge where the counter equals the set point and low on the edge where it equals the clear point. Between those edges it holds its level. Every output change appears one clock edge after the counter value that causes it.
- R5: When a set and a clear fire on the same edge, the output goes low.
- R6: A set or clear point of 0 and one equal to the period act the same way: both fire only on the cycle-start edge, and not when the counter reaches the period.
- R7: A set or clear point greater than the period produces no event. The output can therefore stay high, stay low, or keep its previous level.
- R8: In double-edge mode, on a cycle-start edge, an active set or clear point that equalled the active period fires once more. This happens only when neither new point is 0 or equal to the new period, and neither active point is 0.
- R9: The period, set point, clear point and mode take effect only on an edge where both the cycle-start strobe and the counter enable are high. Changes made mid-cycle do not alter the current cycle.
- R10: Reset drives the output low and clears all active values to 0.
- R11: While the counter enable is low, the output is low on the following edge and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable; output forced low when 0 |
| cyc_start | input | 1 | One-cycle strobe, high while the counter is 0 at a wrap |
| cnt | input | CW | Shared counter value |
| per_nxt | input | CW | Pending period (the counter's top value) |
| set_nxt | input | CW | Pending set point |
| clr_nxt | input | CW | Pending clear point |
| mode_nxt | input | 1 | Pending mode: 0 single-edge, 1 double-edge |
| pwm_out | output | 1 | PWM level |

## Verification
Each output change is due one clock edge after the counter value or strobe that causes it. The boundary decision uses the pending values seen on the cycle-start edge, and it appears on the output together with the newly loaded active values. The bench drives the counter and all pending values on the falling edge. It steps a behavioural model on the rising edge, then compares the model with the output at the next falling edge, every cycle. This gives exactly one clock of latency and no race. The pending values are changed at points that land mid-cycle, so the comparison also shows that nothing takes effect before the next boundary.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DOUBLE = 1'b1
  } pwm_mode_e;
endpackage

// File: rtl/pwm_match_bank.sv
module pwm_match_bank
  import pwm_edge_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] per_nxt,
  input  logic [CW-1:0] set_nxt,
  input  logic [CW-1:0] clr_nxt,
  input  pwm_mode_e     mode_nxt,
  output logic [CW-1:0] per_q,
  output logic [CW-1:0] set_q,
  output logic [CW-1:0] clr_q,
  output pwm_mode_e     mode_q
);
  logic [CW-1:0] per_d, set_d, clr_d;
  pwm_mode_e     mode_d;

  always_comb begin
    per_d  = per_q;
    set_d  = set_q;
    clr_d  = clr_q;
    mode_d = mode_q;
    if (load) begin
      per_d  = per_nxt;
      set_d  = set_nxt;
      clr_d  = clr_nxt;
      mode_d = mode_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      set_q  <= '0;
      clr_q  <= '0;
      mode_q <= MODE_SINGLE;
    end else if (load) begin
      per_q  <= per_d;
      set_q  <= set_d;
      clr_q  <= clr_d;
      mode_q <= mode_d;
    end
  end

  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(per_q) && $stable(set_q) && $stable(clr_q) && $stable(mode_q))); // R9
endmodule

// File: rtl/pwm_edge_decode.sv
module pwm_edge_decode
  import pwm_edge_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] per_q,
  input  logic [CW-1:0] set_q,
  input  logic [CW-1:0] clr_q,
  input  pwm_mode_e     mode_q,
  input  logic [CW-1:0] per_nxt,
  input  logic [CW-1:0] set_nxt,
  input  logic [CW-1:0] clr_nxt,
  input  pwm_mode_e     mode_nxt,
  output logic          set_evt,
  output logic          clr_evt
);
  localparam logic [CW-1:0] ZERO = '0;

  function automatic logic at_bound(input logic [CW-1:0] v, input logic [CW-1:0] p);
    return (v == ZERO) || (v == p);
  endfunction

  function automatic logic mid_hit(input logic [CW-1:0] c, input logic [CW-1:0] v,
                                   input logic [CW-1:0] p);
    return (c == v) && (v != ZERO) && (v < p);
  endfunction

  logic new_set_b, new_clr_b, carry_ok, carry_set, carry_clr;

  always_comb begin
    new_set_b = at_bound(set_nxt, per_nxt);
    new_clr_b = at_bound(clr_nxt, per_nxt);
    carry_ok  = !new_set_b && !new_clr_b && (set_q != ZERO) && (clr_q != ZERO);
    carry_set = carry_ok && (set_q == per_q);
    carry_clr = carry_ok && (clr_q == per_q);
    if (cyc_start) begin
      if (mode_nxt == MODE_SINGLE) begin
        set_evt = 1'b1;
        clr_evt = new_clr_b;
      end else begin
        set_evt = new_set_b || carry_set;
        clr_evt = new_clr_b || carry_clr;
      end
    end else begin
      set_evt = (mode_q == MODE_DOUBLE) && mid_hit(cnt, set_q, per_q);
      clr_evt = mid_hit(cnt, clr_q, per_q);
    end
  end

  AST_OOR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && (set_q > per_q)) |-> !set_evt); // R7
  AST_OOR_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && (clr_q > per_q)) |-> !clr_evt); // R7
endmodule

// File: rtl/pwm_level_reg.sv
module pwm_level_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_evt,
  input  logic clr_evt,
  output logic level_q
);
  logic level_d;

  always_comb begin
    level_d = level_q;
    if (!en)          level_d = 1'b0;
    else if (clr_evt) level_d = 1'b0;
    else if (set_evt) level_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_edge_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cyc_start,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] per_nxt,
  input  logic [CW-1:0] set_nxt,
  input  logic [CW-1:0] clr_nxt,
  input  logic          mode_nxt,
  output logic          pwm_out
);
  logic          load;
  logic [CW-1:0] per_q, set_q, clr_q;
  pwm_mode_e     mode_q, mode_n;
  logic          set_evt, clr_evt;

  assign load   = cnt_en && cyc_start;
  assign mode_n = pwm_mode_e'(mode_nxt);

  pwm_match_bank #(.CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(load),
    .per_nxt(per_nxt), .set_nxt(set_nxt), .clr_nxt(clr_nxt), .mode_nxt(mode_n),
    .per_q(per_q), .set_q(set_q), .clr_q(clr_q), .mode_q(mode_q)
  );

  pwm_edge_decode #(.CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cnt(cnt),
    .per_q(per_q), .set_q(set_q), .clr_q(clr_q), .mode_q(mode_q),
    .per_nxt(per_nxt), .set_nxt(set_nxt), .clr_nxt(clr_nxt), .mode_nxt(mode_n),
    .set_evt(set_evt), .clr_evt(clr_evt)
  );

  pwm_level_reg u_lvl (
    .clk(clk), .rst_n(rst_n), .en(cnt_en),
    .set_evt(set_evt), .clr_evt(clr_evt), .level_q(pwm_out)
  );

  AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> !pwm_out); // R11
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && set_evt && clr_evt) |=> !pwm_out); // R5
  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mode_nxt && (clr_nxt != '0) && (clr_nxt != per_nxt)) |=> pwm_out); // R1
  AST_SINGLE_BOUND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mode_nxt && ((clr_nxt == '0) || (clr_nxt == per_nxt))) |=> !pwm_out); // R3
endmodule

// File: tb/pwm_edge_gen_tb.sv
module pwm_edge_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnt_en;
  logic          cyc_start;
  logic [CW-1:0] cnt;
  logic [CW-1:0] per_nxt, set_nxt, clr_nxt;
  logic          mode_nxt;
  logic          pwm_out;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R10";
  bit    fresh = 1'b1;

  // reference model state
  int m_per, m_set, m_clr, m_mode;
  bit m_pwm;
  int np, ns, nc;
  bit nsb, ncb, go, s, c;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_gen #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cyc_start(cyc_start), .cnt(cnt),
    .per_nxt(per_nxt), .set_nxt(set_nxt), .clr_nxt(clr_nxt), .mode_nxt(mode_nxt),
    .pwm_out(pwm_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 0; m_set = 0; m_clr = 0; m_mode = 0; m_pwm = 1'b0;
    end else if (!cnt_en) begin
      m_pwm = 1'b0;
    end else if (cyc_start) begin
      np = int'(per_nxt); ns = int'(set_nxt); nc = int'(clr_nxt);
      nsb = (ns == 0) || (ns == np);
      ncb = (nc == 0) || (nc == np);
      if (mode_nxt == 1'b0) begin
        s = 1'b1; c = ncb;
      end else begin
        go = !nsb && !ncb && (m_set != 0) && (m_clr != 0);
        s = nsb || (go && (m_set == m_per));
        c = ncb || (go && (m_clr == m_per));
      end
      if (c) m_pwm = 1'b0;
      else if (s) m_pwm = 1'b1;
      m_per = np; m_set = ns; m_clr = nc; m_mode = int'(mode_nxt);
    end else begin
      s = (m_mode == 1) && (int'(cnt) == m_set) && (m_set > 0) && (m_set < m_per);
      c = (int'(cnt) == m_clr) && (m_clr > 0) && (m_clr < m_per);
      if (c) m_pwm = 1'b0;
      else if (s) m_pwm = 1'b1;
    end
  end

  task automatic check(input string t, input bit got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", t, got, exp, $time);
    end
  endtask

  // one cycle: compare at the falling edge, then advance the counter
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, pwm_out, m_pwm);
      if (!cnt_en) begin
        cnt = '0; cyc_start = 1'b0; fresh = 1'b1;
      end else begin
        if (fresh || int'(cnt) >= m_per) cnt = '0;
        else cnt = cnt + 1'b1;
        cyc_start = (cnt == '0);
        fresh = 1'b0;
      end
    end
  endtask

  task automatic run(input string t, input bit md, input int p, input int st,
                     input int cl, input int n);
    tag = t;
    mode_nxt = md;
    per_nxt = CW'(p); set_nxt = CW'(st); clr_nxt = CW'(cl);
    step(n);
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; cyc_start = 1'b0; cnt = '0;
    per_nxt = '0; set_nxt = '0; clr_nxt = '0; mode_nxt = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", pwm_out, 1'b0);
    rst_n = 1'b1;
    step(2);
    cnt_en = 1'b1;
    run("R1", 1'b0, 9, 0, 4, 31);
    run("R2", 1'b0, 9, 0, 12, 23);
    run("R2", 1'b0, 9, 0, 6, 17);
    run("R3", 1'b0, 9, 0, 9, 21);
    run("R3", 1'b0, 9, 0, 0, 19);
    run("R4", 1'b1, 9, 2, 6, 33);
    run("R4", 1'b1, 9, 7, 3, 27);
    run("R5", 1'b1, 9, 5, 5, 22);
    run("R6", 1'b1, 9, 0, 9, 21);
    run("R6", 1'b1, 9, 9, 4, 23);
    run("R6", 1'b1, 9, 0, 5, 21);
    run("R7", 1'b1, 9, 3, 15, 23);
    run("R7", 1'b1, 9, 12, 15, 21);
    run("R7", 1'b1, 9, 12, 2, 21);
    run("R8", 1'b1, 9, 9, 3, 24);
    run("R8", 1'b1, 9, 5, 7, 25);
    run("R8", 1'b1, 9, 2, 9, 22);
    run("R8", 1'b1, 9, 6, 4, 26);
    run("R9", 1'b1, 5, 1, 3, 17);
    run("R9", 1'b0, 7, 0, 3, 13);
    run("R9", 1'b1, 7, 2, 5, 13);
    run("R9", 1'b1, 12, 4, 10, 29);
    tag = "R11";
    cnt_en = 1'b0;
    step(12);
    cnt_en = 1'b1;
    run("R11", 1'b1, 6, 1, 4, 20);
    tag = "R10";
    rst_n = 1'b0;
    step(2);
    check("R10", pwm_out, 1'b0);
    rst_n = 1'b1;
    run("R10", 1'b0, 8, 0, 5, 20);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule